// File: doc/BRIEF.md
# Windowed Data Address Translator

This block turns a 16-bit logical data address into a physical target. Low addresses go straight to on-chip data RAM. A 16 KiB window at 0x8000–0xBFFF is steered by a programmable map register, either into on-chip instruction RAM or into one segment of a large unified memory. The top quarter of the address space is an I/O region. Only a 16-byte hole in that region is reachable, and it lands in data RAM. Any other I/O address produces a bus fault.

A requester presents an address with a strobe. One cycle later the block returns a registered result with a valid flag. The result carries the target code, the physical address or segment offset, the segment number and the fault flag. The map register is loaded through a synchronous write port. The memory arrays and the instruction-side map are outside this block.

Top module: `dwin_xlat`

## Requirements
- R1: While reset is held and on the first cycle after it, rspValid, rspFault, rspTarget, rspSeg and rspAddr are all zero, and the map register holds zero.
- R2: rspValid is high exactly in the cycle after a cycle with reqValid high. In cycles with reqValid low, the other outputs keep their last values.
- R3: Addresses 0x0000–0x7FFF give target code 0 (data RAM), rspAddr equal to the address, rspSeg 0 and no fault.
- R4: Addresses 0x8000–0xBFFF with map bit 12 set give target code 1 (instruction RAM) and rspAddr = map[3:0] × 0x4000 + (address − 0x8000), with rspSeg 0.
- R5: Addresses 0x8000–0xBFFF with map bit 12 clear give target code 2 (unified memory), with rspSeg = map[9:3]. rspAddr is the offset inside the 128 KiB segment, map[2:0] × 0x4000 + (address − 0x8000), so bit 17 is zero.
- R6: Addresses 0xFF00–0xFF0F give target code 0, rspAddr equal to the address and no fault.
- R7: Any address from 0xC000 to 0xFFFF outside 0xFF00–0xFF0F gives rspFault 1, target code 3, rspSeg 0 and rspAddr 0.
- R8: mapWrEn high at a clock edge loads mapWrData into the map register. A request in that same cycle is translated with the previous map value, and the next request sees the new value.
- R9: Map bits 15:13 and 11:10 have no effect on any translation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe |
| reqAddr | input | 16 | Logical data address |
| mapWrEn | input | 1 | Map register write enable |
| mapWrData | input | 16 | Map register write value |
| rspValid | output | 1 | Result valid, one cycle after the request |
| rspTarget | output | 2 | 0 data RAM, 1 instruction RAM, 2 unified memory, 3 none (fault) |
| rspSeg | output | 7 | Unified memory segment number |
| rspAddr | output | 18 | Physical address, or offset within the unified segment |
| rspFault | output | 1 | Bus fault on a reserved I/O address |

## Verification
The hardest case to reach is a map write and a request landing on the same clock edge. The request must use the old map value, and the new one must apply only from the next request. A dedicated task drives both strobes in the same cycle with two map values whose window targets differ. It then issues a second request to the same address and checks that the result changes. The edges of the I/O hole and the extremes of the map page fields are probed at their exact boundary addresses.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  parameter int ADDR_W   = 16;
  parameter int MAP_W    = 16;
  parameter int WIN_W    = 14;
  parameter int SEG_W    = 7;
  parameter int UOFF_W   = 17;
  parameter int PHYS_W   = 18;
  parameter int IRAM_SEL = 12;
  localparam int IPAGE_W = PHYS_W - WIN_W;
  localparam int UPAGE_W = UOFF_W - WIN_W;
  localparam logic [ADDR_W-1:0] WIN_BASE  = ADDR_W'(1) << (ADDR_W - 1);
  localparam logic [ADDR_W-1:0] IO_BASE   = WIN_BASE | (ADDR_W'(1) << WIN_W);
  localparam logic [ADDR_W-1:0] HOLE_MASK = ADDR_W'(16'hFFF0);
  localparam logic [ADDR_W-1:0] HOLE_BASE = ADDR_W'(16'hFF00);

  typedef enum logic [1:0] {
    TGT_DRAM = 2'd0,
    TGT_IRAM = 2'd1,
    TGT_UMEM = 2'd2,
    TGT_NONE = 2'd3
  } tgt_e;

  typedef struct packed {
    logic load;
    logic toDram;
    logic toIram;
    logic toUmem;
    logic toFault;
  } xlat_strb_t;
endpackage

// File: rtl/xlat_ctrl.sv
module xlat_ctrl
  import xlat_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              mapWrEn,
  input  logic [MAP_W-1:0]  mapWrData,
  output xlat_strb_t        strb,
  output logic [MAP_W-1:0]  mapQ
);
  logic inIo, inHole, inWin;

  always_ff @(posedge clk) begin
    if (!rstN)        mapQ <= '0;
    else if (mapWrEn) mapQ <= mapWrData;
  end

  always_comb begin
    inIo   = reqAddr >= IO_BASE;
    inHole = (reqAddr & HOLE_MASK) == HOLE_BASE;
    inWin  = !inIo && (reqAddr >= WIN_BASE);
    strb.load    = reqValid;
    strb.toFault = inIo && !inHole;
    strb.toIram  = inWin && mapQ[IRAM_SEL];
    strb.toUmem  = inWin && !mapQ[IRAM_SEL];
    strb.toDram  = !inWin && !strb.toFault;
  end

  p_map_write_r8: assert property (@(posedge clk) disable iff (!rstN)
    $past(mapWrEn) |-> mapQ == $past(mapWrData));

  p_one_target_r7: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> $countones({strb.toDram, strb.toIram, strb.toUmem, strb.toFault}) == 1);
endmodule

// File: rtl/xlat_datapath.sv
module xlat_datapath
  import xlat_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  xlat_strb_t        strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [MAP_W-1:0]  mapQ,
  output logic              rspValid,
  output tgt_e              rspTarget,
  output logic [SEG_W-1:0]  rspSeg,
  output logic [PHYS_W-1:0] rspAddr,
  output logic              rspFault
);
  logic [WIN_W-1:0] winOff;
  logic [ADDR_W-1:0] winDelta;
  logic unusedMapHigh;

  assign winDelta      = reqAddr - WIN_BASE;
  assign winOff        = winDelta[WIN_W-1:0];
  assign unusedMapHigh = ^mapQ[MAP_W-1:SEG_W+UPAGE_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid  <= 1'b0;
      rspTarget <= TGT_DRAM;
      rspSeg    <= '0;
      rspAddr   <= '0;
      rspFault  <= 1'b0;
    end else begin
      rspValid <= strb.load;
      if (strb.load) begin
        rspFault <= strb.toFault;
        rspSeg   <= '0;
        rspAddr  <= '0;
        if (strb.toFault) begin
          rspTarget <= TGT_NONE;
        end else if (strb.toIram) begin
          rspTarget <= TGT_IRAM;
          rspAddr   <= {mapQ[IPAGE_W-1:0], winOff};
        end else if (strb.toUmem) begin
          rspTarget <= TGT_UMEM;
          rspSeg    <= mapQ[SEG_W+UPAGE_W-1:UPAGE_W];
          rspAddr   <= PHYS_W'({mapQ[UPAGE_W-1:0], winOff});
        end else begin
          rspTarget <= TGT_DRAM;
          rspAddr   <= PHYS_W'(reqAddr);
        end
      end
    end
  end

  p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rstN)
    rspValid == $past(strb.load));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strb.load) |-> $stable(rspAddr) && $stable(rspTarget));

  p_fault_none_r7: assert property (@(posedge clk) disable iff (!rstN)
    rspFault |-> rspTarget == TGT_NONE && rspAddr == '0);

  p_iram_off_r4: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && rspTarget == TGT_IRAM |-> rspAddr[WIN_W-1:0] == $past(reqAddr[WIN_W-1:0]));

  p_umem_range_r5: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && rspTarget == TGT_UMEM |-> rspAddr[PHYS_W-1:UOFF_W] == '0);
endmodule

// File: rtl/dwin_xlat.sv
module dwin_xlat
  import xlat_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              mapWrEn,
  input  logic [MAP_W-1:0]  mapWrData,
  output logic              rspValid,
  output logic [1:0]        rspTarget,
  output logic [SEG_W-1:0]  rspSeg,
  output logic [PHYS_W-1:0] rspAddr,
  output logic              rspFault
);
  xlat_strb_t strb;
  logic [MAP_W-1:0] mapQ;
  tgt_e tgtQ;

  xlat_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .mapWrEn(mapWrEn), .mapWrData(mapWrData), .strb(strb), .mapQ(mapQ)
  );

  xlat_datapath i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .reqAddr(reqAddr), .mapQ(mapQ),
    .rspValid(rspValid), .rspTarget(tgtQ), .rspSeg(rspSeg),
    .rspAddr(rspAddr), .rspFault(rspFault)
  );

  assign rspTarget = tgtQ;
endmodule

// File: tb/test_dwin_xlat.sv
module test_dwin_xlat;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [15:0] reqAddr = '0;
  logic mapWrEn = 1'b0;
  logic [15:0] mapWrData = '0;
  logic rspValid, rspFault;
  logic [1:0] rspTarget;
  logic [6:0] rspSeg;
  logic [17:0] rspAddr;
  int checks = 0;
  int failures = 0;
  logic [15:0] mapModel = '0;

  always #4 clk = ~clk;

  dwin_xlat i_dwin_xlat (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .mapWrEn(mapWrEn), .mapWrData(mapWrData), .rspValid(rspValid),
    .rspTarget(rspTarget), .rspSeg(rspSeg), .rspAddr(rspAddr), .rspFault(rspFault)
  );

  // packed {fault, target, seg, addr}
  function automatic logic [27:0] expect_res(input logic [15:0] a, input logic [15:0] m);
    logic [17:0] off;
    off = 18'(a - 16'h8000);
    if (a >= 16'hC000 && a[15:4] != 12'hFF0) return {1'b1, 2'd3, 7'd0, 18'd0};
    if (a >= 16'h8000 && a < 16'hC000) begin
      if (m[12]) return {1'b0, 2'd1, 7'd0, 18'(m[3:0]) * 18'h4000 + off};
      return {1'b0, 2'd2, m[9:3], 18'(m[2:0]) * 18'h4000 + off};
    end
    return {1'b0, 2'd0, 7'd0, 18'(a)};
  endfunction

  task automatic check(input string req, input logic [27:0] act, input logic [27:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_map(input logic [15:0] v);
    @(negedge clk); mapWrEn = 1'b1; mapWrData = v;
    @(negedge clk); mapWrEn = 1'b0;
    mapModel = v;
  endtask

  task automatic do_req(input string req, input logic [15:0] a);
    @(negedge clk); reqValid = 1'b1; reqAddr = a;
    @(negedge clk); reqValid = 1'b0;
    check(req, {27'd0, rspValid}, 28'd1);
    check(req, {rspFault, rspTarget, rspSeg, rspAddr}, expect_res(a, mapModel));
  endtask

  task automatic t_reset_r1;
    @(negedge clk);
    check("R1", {rspValid, rspFault, rspTarget, rspSeg, rspAddr}, 29'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", {rspValid, rspFault, rspTarget, rspSeg, rspAddr}, 29'd0);
    do_req("R1", 16'h9000);  // map zero: unified seg 0, offset 0x1000
  endtask

  task automatic t_low_r3;
    do_req("R3", 16'h0000);
    do_req("R3", 16'h1234);
    do_req("R3", 16'h7FFF);
  endtask

  task automatic t_iram_r4;
    write_map(16'h1005);
    do_req("R4", 16'h8000);
    do_req("R4", 16'hBFFF);
    write_map(16'h100F);
    do_req("R4", 16'hBFFF);
    check("R4", {10'd0, rspAddr}, 28'h3FFFF);
  endtask

  task automatic t_umem_r5;
    write_map(16'h03FF);
    do_req("R5", 16'hBFFF);
    check("R5", {3'd0, rspSeg, rspAddr}, {3'd0, 7'h7F, 18'h1FFFF});
    write_map(16'h0009);
    do_req("R5", 16'h8010);
    check("R5", {3'd0, rspSeg, rspAddr}, {3'd0, 7'h01, 18'h04010});
  endtask

  task automatic t_hole_r6;
    do_req("R6", 16'hFF00);
    do_req("R6", 16'hFF0F);
  endtask

  task automatic t_fault_r7;
    do_req("R7", 16'hC000);
    do_req("R7", 16'hFEFF);
    do_req("R7", 16'hFF10);
    do_req("R7", 16'hFFFF);
  endtask

  task automatic t_hold_r2;
    logic [27:0] prev;
    do_req("R2", 16'h0042);
    prev = {rspFault, rspTarget, rspSeg, rspAddr};
    reqAddr = 16'hC123;
    @(negedge clk);
    check("R2", {27'd0, rspValid}, 28'd0);
    check("R2", {rspFault, rspTarget, rspSeg, rspAddr}, prev);
  endtask

  task automatic t_same_cycle_r8;
    logic [15:0] oldMap;
    write_map(16'h0011);  // unified seg 2, page 1
    oldMap = mapModel;
    @(negedge clk);
    reqValid = 1'b1; reqAddr = 16'hA000;
    mapWrEn = 1'b1; mapWrData = 16'h1003;
    @(negedge clk);
    reqValid = 1'b0; mapWrEn = 1'b0;
    check("R8", {rspFault, rspTarget, rspSeg, rspAddr}, expect_res(16'hA000, oldMap));
    mapModel = 16'h1003;
    do_req("R8", 16'hA000);
    check("R8", {26'd0, rspTarget}, 28'd1);
  endtask

  task automatic t_ignored_r9;
    logic [27:0] base;
    write_map(16'h0009);
    do_req("R9", 16'h8123);
    base = {rspFault, rspTarget, rspSeg, rspAddr};
    write_map(16'hEC09);
    do_req("R9", 16'h8123);
    check("R9", {rspFault, rspTarget, rspSeg, rspAddr}, base);
    write_map(16'h1005);
    do_req("R9", 16'h8123);
    base = {rspFault, rspTarget, rspSeg, rspAddr};
    write_map(16'hFC05);
    do_req("R9", 16'h8123);
    check("R9", {rspFault, rspTarget, rspSeg, rspAddr}, base);
  endtask

  initial begin
    t_reset_r1();
    t_low_r3();
    t_iram_r4();
    t_umem_r5();
    t_hole_r6();
    t_fault_r7();
    t_hold_r2();
    t_same_cycle_r8();
    t_ignored_r9();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule